// File: doc/BRIEF.md
# Secure Mode Transition Controller

This block holds the one-bit trusted-mode flag of a small processor core and a global gate that blocks interrupts and exceptions. It decodes three transitions: a privileged call that enters the protected partition, a return that leaves it, and a security exception that forces entry. Every entry jumps to the address held in an internal protected entry register and reports whether it came from a call or from an exception. Software can also set and clear the gate directly.

Each cycle the block decides whether the core takes an ordinary interrupt, a non-maskable event, a machine-check event or a general exception, given the mode flag and the gate. A system-management request is remembered in a sticky pending bit. In legacy mode it is delivered directly. In protected mode it turns into an ordinary interrupt with a fixed vector and stays pending until the core is back in legacy mode with the gate clear. Instruction fetch, paging and descriptor tables are outside the block.

Top module: `secure_mode_ctrl`

## Requirements
- R1: After reset the mode flag is 0 (legacy), the gate is clear, the entry register holds ENTRY_RESET and no system-management request is pending.
- R2: An enter call (`enterCall`) while `ring` is not 0 produces no entry and leaves the mode flag unchanged.
- R3: An enter call at `ring` 0 in legacy mode gives, in the same cycle, `entryValid`=1, `entryCause`=2'b01 and `entryVec` equal to the entry register; from the next cycle the mode flag and the gate are both 1. An enter call in protected mode is ignored.
- R4: An exception (`excValid`) whose `excCause` equals SEC_CAUSE (default 4'hE) while the gate is clear is a security exception: it gives `entryValid`=1 with `entryCause`=2'b10 and the same `entryVec`, sets mode and gate from the next cycle, and wins over a simultaneous enter call. It is never reported on `excTake`.
- R5: A secure return (`secReturn`) in protected mode with no entry in the same cycle clears the mode flag and the gate from the next cycle; no other input clears the mode flag.
- R6: While the gate is set, `irqTake`, `nmiTake`, `mceTake`, `excTake`, `smiOut` and `redirIrq` are all 0; while it is clear, each request line is taken in the same cycle.
- R7: `gateSet` sets and `gateClr` clears the gate from the next cycle; set wins over clear, and an entry or a return overrides both.
- R8: In legacy mode with the gate clear a system-management request (`smiReq` or the pending bit) is delivered on `smiOut` in the same cycle and the pending bit is cleared; with the gate set the request is held pending and delivered in the first cycle the gate is clear.
- R9: In protected mode a system-management request never drives `smiOut`; with the gate clear it raises `redirIrq` with `redirVec` = REDIR_VEC (default 8'hF0), and it remains pending until it is delivered after the return to legacy mode.
- R10: Ordinary, non-maskable and machine-check interrupts never change the mode flag.
- R11: `entryLoad` writes `entryData` into the entry register only in protected mode; in legacy mode the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ring | input | 2 | Current privilege ring, 0 is supervisor |
| enterCall | input | 1 | Decoded enter-secure call strobe |
| secReturn | input | 1 | Decoded secure return strobe |
| gateSet | input | 1 | Set the global gate |
| gateClr | input | 1 | Clear the global gate |
| entryLoad | input | 1 | Write strobe for the entry register |
| entryData | input | 16 | New entry register value |
| excValid | input | 1 | Exception raised this cycle |
| excCause | input | 4 | Cause code of the exception |
| irqReq | input | 1 | Ordinary interrupt request |
| nmiReq | input | 1 | Non-maskable event request |
| mceReq | input | 1 | Machine-check event request |
| smiReq | input | 1 | System-management interrupt request |
| secureMode | output | 1 | Mode flag, 1 for the protected partition |
| gateOn | output | 1 | Global gate state |
| entryValid | output | 1 | A protected entry is taken this cycle |
| entryCause | output | 2 | 01 call, 10 security exception, 00 none |
| entryVec | output | 16 | Entry target from the entry register |
| irqTake | output | 1 | Ordinary interrupt taken |
| nmiTake | output | 1 | Non-maskable event taken |
| mceTake | output | 1 | Machine-check event taken |
| excTake | output | 1 | Non-security exception taken |
| smiOut | output | 1 | System-management interrupt delivered |
| redirIrq | output | 1 | Redirected system-management request as ordinary interrupt |
| redirVec | output | 8 | Vector of the redirected interrupt |

## Verification
The bench aims at an enter call from a user ring, which a design that skipped the ring test would turn into a silent switch into protected mode, and at a security exception arriving with an enter call, where the wrong priority reports cause 01. It holds a system-management request across a gate-set window and across a whole protected-mode stay: a design that drops the pending bit loses the request, and one that delivers it in protected mode leaks it on `smiOut` instead of raising `redirIrq`. Entry-register writes in legacy mode and interrupts in protected mode are issued to catch a register that is open to the legacy side or an interrupt that changes the mode.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_CALL   = 2'b01,
    CAUSE_SECEXC = 2'b10
  } entryCause_e;

  // strobes from the control decode to the state registers
  typedef struct packed {
    logic setMode;
    logic clrMode;
    logic setGate;
    logic clrGate;
    logic loadEntry;
    logic keepSmi;
  } smcStrobes_t;

endpackage

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
#(
  parameter int RING_W = 2,
  parameter int CAUSE_W = 4,
  parameter logic [CAUSE_W-1:0] SEC_CAUSE = 4'hE
) (
  input  logic [RING_W-1:0]  ring,
  input  logic               enterCall,
  input  logic               secReturn,
  input  logic               gateSet,
  input  logic               gateClr,
  input  logic               entryLoad,
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic               irqReq,
  input  logic               nmiReq,
  input  logic               mceReq,
  input  logic               smiReq,
  input  logic               modeQ,
  input  logic               gateQ,
  input  logic               smiPendQ,
  output smcStrobes_t        strb,
  output logic               entryValid,
  output logic [1:0]         entryCause,
  output logic               irqTake,
  output logic               nmiTake,
  output logic               mceTake,
  output logic               excTake,
  output logic               smiOut,
  output logic               redirIrq
);

  logic isSecCause;
  logic secEntry;
  logic callEntry;
  logic anyEntry;
  logic retTake;
  logic smiAny;
  logic gateOpen;

  always_comb begin
    gateOpen   = !gateQ;
    isSecCause = (excCause == SEC_CAUSE);
    // the security exception is itself an exception, so the gate blocks it
    secEntry   = excValid && isSecCause && gateOpen;
    callEntry  = enterCall && (ring == '0) && !modeQ && !secEntry;
    anyEntry   = secEntry || callEntry;
    retTake    = secReturn && modeQ && !anyEntry;

    entryValid = anyEntry;
    if (secEntry)       entryCause = CAUSE_SECEXC;
    else if (callEntry) entryCause = CAUSE_CALL;
    else                entryCause = CAUSE_NONE;

    irqTake = irqReq && gateOpen;
    nmiTake = nmiReq && gateOpen;
    mceTake = mceReq && gateOpen;
    excTake = excValid && !isSecCause && gateOpen;

    smiAny   = smiReq || smiPendQ;
    smiOut   = smiAny && !modeQ && gateOpen;
    redirIrq = smiAny && modeQ && gateOpen;

    strb.setMode   = anyEntry;
    strb.clrMode   = retTake;
    strb.setGate   = anyEntry || (!retTake && gateSet);
    strb.clrGate   = retTake || (!anyEntry && !gateSet && gateClr);
    strb.loadEntry = entryLoad && modeQ;
    strb.keepSmi   = smiAny && !smiOut;
  end

endmodule

// File: rtl/smc_dp.sv
module smc_dp
  import smc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ENTRY_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  smcStrobes_t       strb,
  input  logic [ADDR_W-1:0] entryData,
  output logic              modeQ,
  output logic              gateQ,
  output logic              smiPendQ,
  output logic [ADDR_W-1:0] entryQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= 1'b0;
      gateQ    <= 1'b0;
      smiPendQ <= 1'b0;
      entryQ   <= ENTRY_RESET;
    end else begin
      if (strb.setMode)      modeQ <= 1'b1;
      else if (strb.clrMode) modeQ <= 1'b0;

      if (strb.setGate)      gateQ <= 1'b1;
      else if (strb.clrGate) gateQ <= 1'b0;

      smiPendQ <= strb.keepSmi;

      if (strb.loadEntry) entryQ <= entryData;
    end
  end

endmodule

// File: rtl/secure_mode_ctrl.sv
module secure_mode_ctrl
  import smc_pkg::*;
#(
  parameter int RING_W = 2,
  parameter int CAUSE_W = 4,
  parameter int ADDR_W = 16,
  parameter int VEC_W = 8,
  parameter logic [CAUSE_W-1:0] SEC_CAUSE = 4'hE,
  parameter logic [VEC_W-1:0] REDIR_VEC = 8'hF0,
  parameter logic [ADDR_W-1:0] ENTRY_RESET = 16'h0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RING_W-1:0]  ring,
  input  logic               enterCall,
  input  logic               secReturn,
  input  logic               gateSet,
  input  logic               gateClr,
  input  logic               entryLoad,
  input  logic [ADDR_W-1:0]  entryData,
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic               irqReq,
  input  logic               nmiReq,
  input  logic               mceReq,
  input  logic               smiReq,
  output logic               secureMode,
  output logic               gateOn,
  output logic               entryValid,
  output logic [1:0]         entryCause,
  output logic [ADDR_W-1:0]  entryVec,
  output logic               irqTake,
  output logic               nmiTake,
  output logic               mceTake,
  output logic               excTake,
  output logic               smiOut,
  output logic               redirIrq,
  output logic [VEC_W-1:0]   redirVec
);

  smcStrobes_t strb;
  logic modeQ;
  logic gateQ;
  logic smiPendQ;
  logic [ADDR_W-1:0] entryQ;

  smc_ctrl #(
    .RING_W(RING_W), .CAUSE_W(CAUSE_W), .SEC_CAUSE(SEC_CAUSE)
  ) u_ctrl (
    .ring(ring), .enterCall(enterCall), .secReturn(secReturn),
    .gateSet(gateSet), .gateClr(gateClr), .entryLoad(entryLoad),
    .excValid(excValid), .excCause(excCause), .irqReq(irqReq),
    .nmiReq(nmiReq), .mceReq(mceReq), .smiReq(smiReq),
    .modeQ(modeQ), .gateQ(gateQ), .smiPendQ(smiPendQ), .strb(strb),
    .entryValid(entryValid), .entryCause(entryCause),
    .irqTake(irqTake), .nmiTake(nmiTake), .mceTake(mceTake),
    .excTake(excTake), .smiOut(smiOut), .redirIrq(redirIrq)
  );

  smc_dp #(
    .ADDR_W(ADDR_W), .ENTRY_RESET(ENTRY_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .entryData(entryData),
    .modeQ(modeQ), .gateQ(gateQ), .smiPendQ(smiPendQ), .entryQ(entryQ)
  );

  assign secureMode = modeQ;
  assign gateOn     = gateQ;
  assign entryVec   = entryQ;
  assign redirVec   = REDIR_VEC;

endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
  parameter int RING_W = 2,
  parameter int CAUSE_W = 4,
  parameter logic [CAUSE_W-1:0] SEC_CAUSE = 4'hE
) (
  input logic               clk,
  input logic               rstN,
  input logic [RING_W-1:0]  ring,
  input logic               enterCall,
  input logic               secReturn,
  input logic               excValid,
  input logic [CAUSE_W-1:0] excCause,
  input logic               secureMode,
  input logic               gateOn,
  input logic               entryValid,
  input logic [1:0]         entryCause,
  input logic               irqTake,
  input logic               nmiTake,
  input logic               mceTake,
  input logic               excTake,
  input logic               smiOut,
  input logic               redirIrq
);

  AST_USER_CALL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!secureMode && enterCall && ring != '0 && !(excValid && excCause == SEC_CAUSE))
      |=> !secureMode); // R2

  AST_ENTRY_SETS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |=> (secureMode && gateOn)); // R3

  AST_SECEXC_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (entryCause == 2'b10) |-> !excTake); // R4

  AST_MODE_FALL_ON_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (secureMode && !secReturn) |=> secureMode); // R5

  AST_GATE_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    gateOn |-> !(irqTake || nmiTake || mceTake || excTake || smiOut || redirIrq)); // R6

  AST_SMI_NOT_IN_SECURE: assert property (@(posedge clk) disable iff (!rstN)
    secureMode |-> !smiOut); // R9

  AST_ONE_SMI_PATH: assert property (@(posedge clk) disable iff (!rstN)
    $countones({smiOut, redirIrq}) <= 1); // R8

endmodule

bind secure_mode_ctrl smc_checker #(
  .RING_W(RING_W), .CAUSE_W(CAUSE_W), .SEC_CAUSE(SEC_CAUSE)
) u_smc_checker (
  .clk(clk), .rstN(rstN), .ring(ring), .enterCall(enterCall),
  .secReturn(secReturn), .excValid(excValid), .excCause(excCause),
  .secureMode(secureMode), .gateOn(gateOn), .entryValid(entryValid),
  .entryCause(entryCause), .irqTake(irqTake), .nmiTake(nmiTake),
  .mceTake(mceTake), .excTake(excTake), .smiOut(smiOut), .redirIrq(redirIrq)
);

// File: tb/secure_mode_ctrl_test.sv
module secure_mode_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] SEC = 4'hE;
  localparam logic [15:0] ERST = 16'h0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] ring = '0;
  logic enterCall = 0, secReturn = 0, gateSet = 0, gateClr = 0, entryLoad = 0;
  logic [15:0] entryData = '0;
  logic excValid = 0;
  logic [3:0] excCause = '0;
  logic irqReq = 0, nmiReq = 0, mceReq = 0, smiReq = 0;
  logic secureMode, gateOn, entryValid, irqTake, nmiTake, mceTake, excTake;
  logic smiOut, redirIrq;
  logic [1:0] entryCause;
  logic [15:0] entryVec;
  logic [7:0] redirVec;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  // bench model state
  logic mMode, mGate, mPend;
  logic [15:0] mEntry;

  always #(CLK_PERIOD/2) clk = ~clk;

  secure_mode_ctrl uut (
    .clk(clk), .rstN(rstN), .ring(ring), .enterCall(enterCall),
    .secReturn(secReturn), .gateSet(gateSet), .gateClr(gateClr),
    .entryLoad(entryLoad), .entryData(entryData), .excValid(excValid),
    .excCause(excCause), .irqReq(irqReq), .nmiReq(nmiReq), .mceReq(mceReq),
    .smiReq(smiReq), .secureMode(secureMode), .gateOn(gateOn),
    .entryValid(entryValid), .entryCause(entryCause), .entryVec(entryVec),
    .irqTake(irqTake), .nmiTake(nmiTake), .mceTake(mceTake),
    .excTake(excTake), .smiOut(smiOut), .redirIrq(redirIrq), .redirVec(redirVec)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] expCause(input logic sec, input logic call);
    return sec ? 2'b10 : (call ? 2'b01 : 2'b00);
  endfunction

  task automatic clearInputs();
    ring = '0; enterCall = 0; secReturn = 0; gateSet = 0; gateClr = 0;
    entryLoad = 0; excValid = 0; excCause = '0;
    irqReq = 0; nmiReq = 0; mceReq = 0; smiReq = 0;
  endtask

  // inputs are set at a falling edge; check, then advance the model at the rise
  task automatic step();
    logic secE, callE, ent, retE, smiAny, sOut;
    #1;
    secE   = excValid && excCause == SEC && !mGate;
    callE  = enterCall && ring == 2'd0 && !mMode && !secE;
    ent    = secE || callE;
    retE   = secReturn && mMode && !ent;
    smiAny = smiReq || mPend;
    sOut   = smiAny && !mMode && !mGate;
    chk(secureMode, mMode, "R3/R5/R10 mode");
    chk(gateOn, mGate, "R7 gate");
    chk(entryValid, ent, "R2/R3/R4 entryValid");
    chk(entryCause, expCause(secE, callE), "R4 entryCause");
    chk(entryVec, mEntry, "R11 entryVec");
    chk(irqTake, irqReq && !mGate, "R6 irqTake");
    chk(nmiTake, nmiReq && !mGate, "R6 nmiTake");
    chk(mceTake, mceReq && !mGate, "R6 mceTake");
    chk(excTake, excValid && excCause != SEC && !mGate, "R6 excTake");
    chk(smiOut, sOut, "R8 smiOut");
    chk(redirIrq, smiAny && mMode && !mGate, "R9 redirIrq");
    chk(redirVec, 8'hF0, "R9 redirVec");
    @(posedge clk);
    if (entryLoad && mMode) mEntry = entryData;
    if (ent) mGate = 1;
    else if (retE) mGate = 0;
    else if (gateSet) mGate = 1;
    else if (gateClr) mGate = 0;
    if (ent) mMode = 1;
    else if (retE) mMode = 0;
    mPend = smiAny && !sOut;
    @(negedge clk);
    clearInputs();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finish();
    end
  end

  initial begin
    mMode = 0; mGate = 0; mPend = 0; mEntry = ERST;
    clearInputs();
    repeat (3) @(negedge clk);
    chk(secureMode, 0, "R1 reset mode");
    chk(gateOn, 0, "R1 reset gate");
    chk(entryVec, ERST, "R1 reset entry");
    chk(smiOut, 0, "R1 reset smi");
    rstN = 1;

    // R2: call from user ring
    ring = 2'd3; enterCall = 1; step();
    chk(secureMode, 0, "R2 user call keeps mode");
    // R11: load in legacy mode ignored
    entryLoad = 1; entryData = 16'hBEEF; step();
    chk(entryVec, ERST, "R11 legacy load ignored");
    // R8: smi with gate set pending
    gateSet = 1; step();
    smiReq = 1; step();
    chk(smiOut, 0, "R8 held while gate set");
    gateClr = 1; step();
    chk(smiOut, 1, "R8 delivered after gate clears");
    step();
    chk(smiOut, 0, "R8 pending cleared");
    // R3: call at ring 0
    enterCall = 1; step();
    chk(secureMode, 1, "R3 mode set");
    chk(gateOn, 1, "R3 gate set");
    // R11: load in protected mode
    entryLoad = 1; entryData = 16'h4A5C; step();
    chk(entryVec, 16'h4A5C, "R11 load in protected mode");
    // R9: smi in protected mode
    gateClr = 1; step();
    smiReq = 1; step();
    step();
    chk(redirIrq, 1, "R9 redirect persists");
    chk(smiOut, 0, "R9 no direct delivery");
    // R10: interrupts do not change mode
    irqReq = 1; nmiReq = 1; mceReq = 1; step();
    chk(secureMode, 1, "R10 mode after interrupts");
    // R5: return, then delivery
    secReturn = 1; step();
    chk(secureMode, 0, "R5 mode cleared");
    chk(smiOut, 1, "R9 delivered after return");
    step();
    // R4: security exception together with call
    excValid = 1; excCause = SEC; enterCall = 1; #1;
    chk(entryCause, 2'b10, "R4 secexc wins");
    step();
    chk(secureMode, 1, "R4 mode set");
    secReturn = 1; gateSet = 1; step();
    chk(gateOn, 0, "R7 return overrides set");

    for (int i = 0; i < 3000; i++) begin
      ring      = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      enterCall = ($urandom % 8) == 0;
      secReturn = ($urandom % 8) == 0;
      gateSet   = ($urandom % 8) == 0;
      gateClr   = ($urandom % 5) == 0;
      entryLoad = ($urandom % 8) == 0;
      entryData = 16'($urandom);
      excValid  = ($urandom % 8) == 0;
      excCause  = ($urandom % 2) ? SEC : 4'($urandom);
      irqReq    = $urandom % 2;
      nmiReq    = ($urandom % 4) == 0;
      mceReq    = ($urandom % 6) == 0;
      smiReq    = ($urandom % 8) == 0;
      step();
    end
    finish();
  end

  initial begin
    process::self().srandom(32'd1234);
  end

endmodule